// File: doc/BRIEF.md
# Serial-Bus Register File Slave

This block is a two-wire serial bus slave that connects a master to a small bank of eleven 8-bit registers. These registers hold the control, offset and timekeeping registers of a clock/calendar. The block oversamples the clock and data lines on the system clock and finds START and STOP conditions. It matches a fixed 7-bit device address and keeps a register pointer. The pointer steps through the bank and wraps back to the first entry after the last one. The block pulls the data line low through an open-drain enable only to acknowledge or to send read data.

The register storage itself sits in the neighbouring calendar and control logic. That logic sees a one-cycle write strobe with address and data, and a one-cycle read strobe. On a read strobe it must return the addressed byte on `rd_data` in the same cycle. A `busy` level spans each transaction addressed to this device, so the neighbour can hold its time counters still while the master reads or writes. A dedicated command byte written to the first register produces a reset pulse instead of a write. The neighbour uses that pulse to restore its defaults.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The device answers address 1010001 (address byte A2h for write, A3h for read, R/W in bit 0) with an acknowledge. Any other address gets no acknowledge. The block then drives nothing and strobes nothing until the next START.
- R2: The first byte after a write address loads the pointer from its low 4 bits and ignores the upper 4 bits. A resulting value above 0Ah loads 00h.
- R3: Each later written byte pulses `reg_wr` for one cycle with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then advances by one.
- R4: When the pointer advances from 0Ah, both on writes and on reads, it goes to 00h.
- R5: A data byte of 58h written while the pointer is 00h pulses `sw_reset` instead of `reg_wr` and leaves the pointer at 00h. The next byte is therefore written to 00h.
- R6: In a read transfer, each byte is fetched with a one-cycle `reg_rd` pulse at `reg_addr`. The byte is sent most significant bit first, and the pointer advances after each byte.
- R7: After the master answers a read byte with no acknowledge, the block releases the data line and sends nothing more until a STOP or START.
- R8: `busy` rises at START and falls at STOP or on an address mismatch.
- R9: A repeated START ends a write and begins a new address phase with the pointer kept, so a pointer set by a write can be followed directly by a read.
- R10: Every byte received by an addressed device is acknowledged by holding the data line low across the ninth clock high period.
- R11: After reset, `busy`, `sda_oe`, `reg_wr`, `reg_rd` and `sw_reset` are low and `reg_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Transaction in progress; holds time counters |
| reg_addr | output | 4 | Current register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle read fetch strobe |
| rd_data | input | 8 | Register contents at `reg_addr`, sampled with `reg_rd` |
| sw_reset | output | 1 | One-cycle register-defaults command |

## Verification
A wrong bit count or a wrong state shows up first at the acknowledge slot. The data line is then high where it should be low, or low during a data bit, within one byte time of the fault. A corrupted pointer shows only indirectly. A write then lands in the wrong entry of the neighbour's storage, or a read returns a byte from the wrong entry. The bench therefore reads back through the bus every entry it wrote, including across the wrap. A `busy` that sticks or drops early is visible at the port a few cycles after the START or STOP that should have changed it.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1010001,
  parameter int         NREGS    = 11,
  parameter logic [7:0] RST_CMD  = 8'h58
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       busy,
  output logic [3:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic [7:0] rd_data,
  output logic       sw_reset
);
  localparam int         PW   = 4;
  localparam logic [PW-1:0] LAST = PW'(NREGS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP} st_t;

  st_t           st;
  logic [1:0]    scl_s, sda_s;
  logic          scl_q, sda_q;
  logic [7:0]    sh;
  logic [3:0]    cnt;
  logic [PW-1:0] ptr;
  logic          rw, first, nack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end

  wire scl_r     = scl_s[1] & ~scl_q;
  wire scl_f     = ~scl_s[1] & scl_q;
  wire start_evt = scl_s[1] & scl_q & sda_q & ~sda_s[1];
  wire stop_evt  = scl_s[1] & scl_q & ~sda_q & sda_s[1];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire is_cmd  = (ptr == '0) && (sh == RST_CMD);
  wire wr_fire = scl_f && (st == S_WDAT) && (cnt == 4'd8) && !first;
  wire rd_fire = scl_f && rw && ((st == S_AACK) || (st == S_RACK && !nack));

  assign reg_wr    = wr_fire && !is_cmd;
  assign sw_reset  = wr_fire && is_cmd;
  assign reg_rd    = rd_fire;
  assign reg_wdata = sh;
  assign reg_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; nack <= 1'b0; busy <= 1'b0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= S_ADDR; cnt <= '0; busy <= 1'b1; sda_oe <= 1'b0; first <= 1'b1;
    end else if (stop_evt) begin
      st <= S_IDLE; busy <= 1'b0; sda_oe <= 1'b0;
    end else if (rd_fire) begin
      sh <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0; st <= S_RDAT;
    end else begin
      case (st)
        S_ADDR:
          if (scl_r) begin
            sh <= {sh[6:0], sda_s[1]}; cnt <= cnt + 1'b1;
          end else if (scl_f && cnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin
              rw <= sh[0]; sda_oe <= 1'b1; st <= S_AACK;
            end else begin
              st <= S_SKIP; busy <= 1'b0;
            end
          end
        S_AACK:
          if (scl_f) begin
            sda_oe <= 1'b0; cnt <= '0; st <= S_WDAT;
          end
        S_WDAT:
          if (scl_r) begin
            sh <= {sh[6:0], sda_s[1]}; cnt <= cnt + 1'b1;
          end else if (scl_f && cnt == 4'd8) begin
            sda_oe <= 1'b1; st <= S_WACK; first <= 1'b0;
            if (first)       ptr <= (sh[PW-1:0] > LAST) ? '0 : sh[PW-1:0];
            else if (is_cmd) ptr <= '0;
            else             ptr <= step(ptr);
          end
        S_WACK:
          if (scl_f) begin
            sda_oe <= 1'b0; cnt <= '0; st <= S_WDAT;
          end
        S_RDAT:
          if (scl_f) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; ptr <= step(ptr); st <= S_RACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 1'b1;
            end
          end
        S_RACK:
          if (scl_r) nack <= sda_s[1];
          else if (scl_f) st <= S_SKIP;
        default: ;
      endcase
    end

  a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  a_r8_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!busy && !sda_oe));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == LAST) |=> (reg_addr == '0));
  a_r5_cmd_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (reg_addr == '0));
  a_r3_strobes_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd || sw_reset) |-> busy);
  a_r1_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
  a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr <= LAST);
endmodule

// File: tb/i2c_regfile_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regfile_slave_tb_top;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy, reg_wr, reg_rd, sw_reset;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, rd_data;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regfile_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .busy(busy), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .rd_data(rd_data), .sw_reset(sw_reset));

  logic [7:0] regs [0:10];
  logic [7:0] expv [0:10];
  int wr_cnt = 0, rst_cnt = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] dflt(int i);
    return (i == 7 || i == 9) ? 8'h01 : 8'h00;
  endfunction

  assign rd_data = (reg_addr <= 4'd10) ? regs[reg_addr] : 8'h00;

  always_ff @(posedge clk)
    if (!rst_n || sw_reset) begin
      for (int i = 0; i < 11; i++) regs[i] <= dflt(i);
      if (sw_reset) rst_cnt <= rst_cnt + 1;
    end else if (reg_wr) begin
      regs[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(int n); repeat (n) @(negedge clk); endtask

  task automatic b_start;
    sda_m = 1'b1; hw(H); scl = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl = 1'b0; hw(H);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; hw(H); scl = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic b_wr(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H); scl = 1'b1; hw(H); scl = 1'b0;
    end
    sda_m = 1'b1; hw(H); scl = 1'b1; hw(H/2); ack = ~sda_bus; hw(H/2); scl = 1'b0;
  endtask

  task automatic b_rd(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); scl = 1'b1; hw(H/2); d[i] = sda_bus; hw(H/2); scl = 1'b0;
    end
    sda_m = ~give_ack; hw(H); scl = 1'b1; hw(H); scl = 1'b0; hw(2); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit a;
    b_start; b_wr(8'hA2, a); chk("R1 addr ack", a, 1); b_wr(p, a); chk("R10 ptr ack", a, 1);
  endtask

  task automatic t_reset;
    chk("R11 busy", busy, 0); chk("R11 sda_oe", sda_oe, 0);
    chk("R11 strobes", {reg_wr, reg_rd, sw_reset}, 0); chk("R11 addr", reg_addr, 0);
  endtask

  task automatic t_write_basic;
    bit a;
    set_ptr(8'h04);
    chk("R8 busy in txn", busy, 1);
    b_wr(8'h11, a); chk("R10 data ack", a, 1);
    b_wr(8'h22, a); chk("R10 data ack", a, 1);
    b_stop; hw(5);
    expv[4] = 8'h11; expv[5] = 8'h22;
    chk("R3 reg4", regs[4], expv[4]); chk("R3 reg5", regs[5], expv[5]);
    chk("R8 busy after stop", busy, 0);
  endtask

  task automatic t_write_wrap;
    bit a;
    set_ptr(8'h0A); b_wr(8'h33, a); b_wr(8'h44, a); b_stop; hw(5);
    expv[10] = 8'h33; expv[0] = 8'h44;
    chk("R4 reg10", regs[10], expv[10]); chk("R4 wrapped reg0", regs[0], expv[0]);
  endtask

  task automatic t_read_rstart;
    bit a; logic [7:0] d; bit seen;
    set_ptr(8'h04);
    b_start; b_wr(8'hA3, a); chk("R9 read addr after rstart", a, 1);
    b_rd(1'b1, d); chk("R6 read byte0", d, expv[4]);
    b_rd(1'b1, d); chk("R6 read byte1", d, expv[5]);
    b_rd(1'b0, d); chk("R6 read byte2", d, expv[6]);
    seen = 1'b1;
    for (int i = 0; i < 9; i++) begin
      hw(H); scl = 1'b1; hw(H/2); seen &= sda_bus; hw(H/2); scl = 1'b0;
    end
    chk("R7 line released after nack", seen, 1);
    chk("R8 busy held until stop", busy, 1);
    b_stop; hw(5);
  endtask

  task automatic t_read_wrap;
    bit a; logic [7:0] d;
    set_ptr(8'h0A); b_stop;
    b_start; b_wr(8'hA3, a);
    b_rd(1'b1, d); chk("R4 read reg10", d, expv[10]);
    b_rd(1'b0, d); chk("R4 read wrapped reg0", d, expv[0]);
    b_stop; hw(5);
  endtask

  task automatic t_ptr_bits;
    bit a; logic [7:0] d;
    set_ptr(8'hF5); b_wr(8'h5A, a); b_stop; hw(5);
    expv[5] = 8'h5A; chk("R2 upper bits ignored", regs[5], expv[5]);
    set_ptr(8'h05); b_start; b_wr(8'hA3, a); b_rd(1'b0, d); b_stop;
    chk("R2 readback", d, expv[5]);
    set_ptr(8'h0C); b_wr(8'h77, a); b_stop; hw(5);
    expv[0] = 8'h77; chk("R2 out of range to 00", regs[0], expv[0]);
  endtask

  task automatic t_mismatch;
    bit a; int w0;
    w0 = wr_cnt;
    b_start; b_wr(8'hA4, a); chk("R1 wrong addr nack", a, 0);
    hw(5); chk("R8 busy drops on mismatch", busy, 0);
    b_wr(8'h00, a); chk("R1 ignored byte nack", a, 0);
    b_wr(8'h9E, a);
    chk("R1 no writes while ignored", wr_cnt, w0);
    b_stop; hw(5);
  endtask

  task automatic t_soft_reset;
    bit a; int w0, r0;
    w0 = wr_cnt; r0 = rst_cnt;
    set_ptr(8'h00); b_wr(8'h58, a); chk("R10 cmd ack", a, 1);
    b_wr(8'h66, a); b_stop; hw(5);
    for (int i = 0; i < 11; i++) expv[i] = dflt(i);
    expv[0] = 8'h66;
    chk("R5 reset pulse", rst_cnt, r0 + 1);
    chk("R5 one write only", wr_cnt, w0 + 1);
    chk("R5 next byte at 00", regs[0], expv[0]);
    chk("R5 defaults reg4", regs[4], expv[4]);
    chk("R5 defaults reg7", regs[7], expv[7]);
  endtask

  initial begin
    for (int i = 0; i < 11; i++) expv[i] = dflt(i);
    hw(4); t_reset; rst_n = 1'b1; hw(4); t_reset;
    t_write_basic;
    t_write_wrap;
    t_read_rstart;
    t_read_wrap;
    t_ptr_bits;
    t_mismatch;
    t_soft_reset;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule